// File: doc/BRIEF.md
# Timer, Divider and Watchdog Unit

This block is the time base of a small 4-bit controller. It holds two down-counting timers, a free-running divider and a watchdog. The first timer is one-shot. It counts ticks from a prescaler that can divide the system clock by a small or a large power of two. The second timer reloads by itself. It counts either a prescaled internal clock or rising edges on an external event pin. The divider raises an interrupt each time it wraps. The watchdog emits a one-cycle reset pulse unless software clears it in time. It has two selectable lengths and can be removed by a static parameter.

Software reaches the unit through a write port (address, data, strobe) and a combinational read port. The writable registers are: the timer 0 load value, the timer 1 reload value, a control register, a flag register that clears on writing 1, and a command register. Three sticky interrupt flags and the watchdog reset pulse leave the block as plain outputs.

Top module: `tick_unit`

## Requirements
- R1: After a synchronous reset, all of the following read as zero and stay low: the timer counts, the control register, the flag register, the three interrupt outputs and `wdt_rst`.
- R2: With control bit 0 = 0, writing a nonzero value V to address 0 starts timer 0. Its prescaler restarts on that write. `irq_t0` rises exactly V·2^PRE_FAST_LOG2 clocks after the write edge. The count then reads 0.
- R3: With control bit 0 = 1, timer 0 ticks once every 2^PRE_SLOW_LOG2 clocks, so `irq_t0` rises exactly V·2^PRE_SLOW_LOG2 clocks after the write.
- R4: After timer 0 reaches 0, or after 0 is written to address 0, timer 0 stays stopped at 0 and raises no further flag until it is written again.
- R5: With control bit 2 = 1 and bit 1 = 0, writing R to address 1 loads both the reload register and the count, and restarts the internal prescaler. Timer 1 then steps every 2^PRE_FAST_LOG2 clocks. When it steps at a count of 1 (or 0), it reloads R and sets `irq_t1`, so the flag repeats every R·2^PRE_FAST_LOG2 clocks.
- R6: With control bit 1 = 1, timer 1 steps once per rising edge of `ev_pin`. The pin passes through two synchronising flops, so the count changes on the third clock edge after the pin rises. A steady level or a falling edge has no effect on the count.
- R7: With control bit 2 = 0, the timer 1 count holds its value and `irq_t1` stays low.
- R8: The divider counts every clock. Writing bit 0 of address 4 clears it to 0. `irq_div` rises exactly 2^DIV_W clocks after the clear, when the divider wraps from all ones to zero.
- R9: A divider clear that lands on the wrapping cycle wins. No flag is raised, and the next flag comes 2^DIV_W clocks after that clear.
- R10: The flags sit in address 3, with the divider at bit 0, timer 0 at bit 1 and timer 1 at bit 2. Writing 1 to a bit clears it. Writing 0 leaves it set. An event in the same cycle as a clear leaves the flag set.
- R11: Writing bit 1 of address 4 clears the watchdog. With control bit 3 = 0, `wdt_rst` pulses high for one clock 2^WDT_LONG_W clocks after the clear; with bit 3 = 1 it pulses 2^WDT_SHORT_W clocks after the clear. The count then restarts, so pulses repeat with the same period.
- R12: With WDT_ENABLE = 0, `wdt_rst` never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | TMR_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | TMR_W | Read data (combinational) |
| ev_pin | input | 1 | External event input for timer 1 (asynchronous) |
| irq_div | output | 1 | Divider interrupt flag |
| irq_t0 | output | 1 | Timer 0 interrupt flag |
| irq_t1 | output | 1 | Timer 1 interrupt flag |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the unit with a 6-bit divider, an 8-bit long and a 5-bit short watchdog, and prescale exponents of 2 and 4. With these sizes the divider wrap, both watchdog expiries and the slow timer 0 period all land on exact, predictable edges within a few hundred clocks. The clear-on-wrap collision and repeated watchdog pulses can then be hit by counting cycles. A second copy is built with WDT_ENABLE = 0 to show that the disabled watchdog stays silent.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [2:0] {
        ADR_T0   = 3'd0,
        ADR_T1   = 3'd1,
        ADR_CTRL = 3'd2,
        ADR_FLAG = 3'd3,
        ADR_CMD  = 3'd4
    } reg_addr_e;

    // control register, bit 3 down to bit 0
    typedef struct packed {
        logic wdt_short;
        logic t1_run;
        logic t1_ext;
        logic t0_slow;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int FLAG_N   = 3;
    localparam int FLG_DIV  = 0;
    localparam int FLG_T0   = 1;
    localparam int FLG_T1   = 2;
    localparam int CMD_DIV  = 0;
    localparam int CMD_WDT  = 1;

    function automatic logic reg_hit(input logic en, input logic [2:0] adr,
                                     input reg_addr_e target);
        return en && (adr == target);
    endfunction

endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int LOG2_FAST = 2,
    parameter int LOG2_SLOW = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic slow_sel,
    output logic tick
);
    localparam int CW = (LOG2_SLOW > LOG2_FAST) ? LOG2_SLOW : LOG2_FAST;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign tick = slow_sel ? (&cnt[LOG2_SLOW-1:0]) : (&cnt[LOG2_FAST-1:0]);
endmodule

// File: rtl/tick_edge_sync.sv
module tick_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], pin};
    end

    // sh[0], sh[1] synchronise; sh[2] remembers the previous level
    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/tick_downcount.sv
module tick_downcount #(
    parameter int W           = 8,
    parameter bit AUTO_RELOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         run_en,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         evt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic active;
    logic step;

    generate
        if (AUTO_RELOAD) begin : g_reload
            assign active = 1'b1;
        end else begin : g_oneshot
            logic act_q;
            always_ff @(posedge clk) begin
                if (rst)       act_q <= 1'b0;
                else if (load) act_q <= |load_val;
                else if (evt)  act_q <= 1'b0;
            end
            assign active = act_q;
        end
    endgenerate

    assign step = tick & run_en & active & ~load;
    assign evt  = step & (cnt <= ONE);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= (cnt <= ONE) ? reload_val : cnt - ONE;
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic         evt
);
    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign evt = (&cnt) & ~clear;
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
    parameter int LONG_W  = 18,
    parameter int SHORT_W = 14,
    parameter bit ENABLE  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic short_sel,
    output logic pulse
);
    logic [LONG_W-1:0] cnt;
    logic              at_end;

    assign at_end = short_sel ? (&cnt[SHORT_W-1:0]) : (&cnt);

    always_ff @(posedge clk) begin
        if (rst || clear || !ENABLE) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            cnt   <= at_end ? '0 : cnt + 1'b1;
            pulse <= at_end;
        end
    end
endmodule

// File: rtl/tick_unit.sv
module tick_unit
    import tick_pkg::*;
#(
    parameter int TMR_W         = 8,
    parameter int DIV_W         = 14,
    parameter int WDT_LONG_W    = 18,
    parameter int WDT_SHORT_W   = 14,
    parameter int PRE_FAST_LOG2 = 2,
    parameter int PRE_SLOW_LOG2 = 10,
    parameter bit WDT_ENABLE    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [TMR_W-1:0] rd_data,
    input  logic             ev_pin,
    output logic             irq_div,
    output logic             irq_t0,
    output logic             irq_t1,
    output logic             wdt_rst
);
    logic wr_t0, wr_t1, wr_ctrl, wr_flag, wr_cmd;
    assign wr_t0   = reg_hit(wr_en, wr_addr, ADR_T0);
    assign wr_t1   = reg_hit(wr_en, wr_addr, ADR_T1);
    assign wr_ctrl = reg_hit(wr_en, wr_addr, ADR_CTRL);
    assign wr_flag = reg_hit(wr_en, wr_addr, ADR_FLAG);
    assign wr_cmd  = reg_hit(wr_en, wr_addr, ADR_CMD);

    ctrl_t            ctrl_q;
    logic [TMR_W-1:0] t1_reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            t1_reload <= '0;
        end else begin
            if (wr_ctrl) ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_t1)   t1_reload <= wr_data;
        end
    end

    // timer 0: one-shot, selectable prescale
    logic             t0_tick, evt_t0;
    logic [TMR_W-1:0] t0_cnt;

    tick_prescale #(.LOG2_FAST(PRE_FAST_LOG2), .LOG2_SLOW(PRE_SLOW_LOG2)) u_pre0 (
        .clk(clk), .rst(rst), .restart(wr_t0), .slow_sel(ctrl_q.t0_slow), .tick(t0_tick)
    );

    tick_downcount #(.W(TMR_W), .AUTO_RELOAD(1'b0)) u_t0 (
        .clk(clk), .rst(rst), .load(wr_t0), .load_val(wr_data), .reload_val('0),
        .run_en(1'b1), .tick(t0_tick), .cnt(t0_cnt), .evt(evt_t0)
    );

    // timer 1: auto-reload, internal or external source
    logic             t1_int_tick, ev_rise, t1_tick, evt_t1;
    logic [TMR_W-1:0] t1_cnt;

    tick_prescale #(.LOG2_FAST(PRE_FAST_LOG2), .LOG2_SLOW(PRE_FAST_LOG2)) u_pre1 (
        .clk(clk), .rst(rst), .restart(wr_t1), .slow_sel(1'b0), .tick(t1_int_tick)
    );

    tick_edge_sync u_evsync (.clk(clk), .rst(rst), .pin(ev_pin), .rise(ev_rise));

    assign t1_tick = ctrl_q.t1_ext ? ev_rise : t1_int_tick;

    tick_downcount #(.W(TMR_W), .AUTO_RELOAD(1'b1)) u_t1 (
        .clk(clk), .rst(rst), .load(wr_t1), .load_val(wr_data), .reload_val(t1_reload),
        .run_en(ctrl_q.t1_run), .tick(t1_tick), .cnt(t1_cnt), .evt(evt_t1)
    );

    // divider and watchdog
    logic [DIV_W-1:0] div_cnt;
    logic             evt_div;

    tick_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .clear(wr_cmd && wr_data[CMD_DIV]), .cnt(div_cnt), .evt(evt_div)
    );

    tick_watchdog #(.LONG_W(WDT_LONG_W), .SHORT_W(WDT_SHORT_W), .ENABLE(WDT_ENABLE)) u_wdt (
        .clk(clk), .rst(rst), .clear(wr_cmd && wr_data[CMD_WDT]),
        .short_sel(ctrl_q.wdt_short), .pulse(wdt_rst)
    );

    // sticky flags, set has priority over write-one-to-clear
    logic [FLAG_N-1:0] flag_q, flag_evt, flag_clr;
    assign flag_evt = {evt_t1, evt_t0, evt_div};
    assign flag_clr = wr_flag ? wr_data[FLAG_N-1:0] : '0;

    generate
        for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) flag_q[g] <= 1'b0;
                else     flag_q[g] <= (flag_q[g] & ~flag_clr[g]) | flag_evt[g];
            end
        end
    endgenerate

    assign irq_div = flag_q[FLG_DIV];
    assign irq_t0  = flag_q[FLG_T0];
    assign irq_t1  = flag_q[FLG_T1];

    always_comb begin
        case (rd_addr)
            ADR_T0:   rd_data = t0_cnt;
            ADR_T1:   rd_data = t1_cnt;
            ADR_CTRL: rd_data = TMR_W'(ctrl_q);
            ADR_FLAG: rd_data = TMR_W'(flag_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tick_unit_chk.sv
module tick_unit_chk
    import tick_pkg::*;
#(
    parameter int TW = 8,
    parameter int DW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [2:0]    clr_bits,
    input logic          irq_div,
    input logic          irq_t0,
    input logic          irq_t1,
    input logic          wdt_rst,
    input logic [TW-1:0] t0_cnt,
    input logic [TW-1:0] t1_cnt,
    input logic [TW-1:0] t1_reload,
    input logic [DW-1:0] div_cnt,
    input logic          t1_run,
    input logic          evt_t0,
    input logic          evt_t1,
    input logic          evt_div
);
    logic wr_flag, wr_t0, wr_t1;
    assign wr_flag = wr_en && (wr_addr == ADR_FLAG);
    assign wr_t0   = wr_en && (wr_addr == ADR_T0);
    assign wr_t1   = wr_en && (wr_addr == ADR_T1);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    a_r10_t0_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_t0) |-> ($past(rst) || $past(wr_flag && clr_bits[FLG_T0])));

    a_r10_t1_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_t1) |-> ($past(rst) || $past(wr_flag && clr_bits[FLG_T1])));

    a_r10_div_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_div) |-> ($past(rst) || $past(wr_flag && clr_bits[FLG_DIV])));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt_t0 |=> irq_t0);

    a_r4_t0_stops: assert property (@(posedge clk) disable iff (rst)
        (evt_t0 && !wr_t0) |=> (t0_cnt == '0));

    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (evt_t1 && !wr_t1) |=> (t1_cnt == $past(t1_reload)) && irq_t1);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!t1_run && !wr_t1) |=> $stable(t1_cnt));

    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        evt_div |=> (div_cnt == '0) && irq_div);
endmodule

bind tick_unit tick_unit_chk #(.TW(TMR_W), .DW(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .clr_bits(wr_data[2:0]),
    .irq_div(irq_div), .irq_t0(irq_t0), .irq_t1(irq_t1), .wdt_rst(wdt_rst),
    .t0_cnt(t0_cnt), .t1_cnt(t1_cnt), .t1_reload(t1_reload), .div_cnt(div_cnt),
    .t1_run(ctrl_q.t1_run), .evt_t0(evt_t0), .evt_t1(evt_t1), .evt_div(evt_div)
);

// File: tb/test_tick_unit.sv
module test_tick_unit;
    import tick_pkg::*;

    localparam int TW = 8, DIVW = 6, WL = 8, WS = 5, PF = 2, PS = 4;

    logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, ev_pin = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, rd_data_off;
    logic       irq_div, irq_t0, irq_t1, wdt_rst;
    logic       irq_div_off, irq_t0_off, irq_t1_off, wdt_rst_off;

    always #2 clk = ~clk;

    tick_unit #(.TMR_W(TW), .DIV_W(DIVW), .WDT_LONG_W(WL), .WDT_SHORT_W(WS),
                .PRE_FAST_LOG2(PF), .PRE_SLOW_LOG2(PS), .WDT_ENABLE(1'b1)) i_tick_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_pin(ev_pin), .irq_div(irq_div),
        .irq_t0(irq_t0), .irq_t1(irq_t1), .wdt_rst(wdt_rst));

    tick_unit #(.TMR_W(TW), .DIV_W(DIVW), .WDT_LONG_W(WL), .WDT_SHORT_W(WS),
                .PRE_FAST_LOG2(PF), .PRE_SLOW_LOG2(PS), .WDT_ENABLE(1'b0)) i_tick_unit_off (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_off), .ev_pin(ev_pin), .irq_div(irq_div_off),
        .irq_t0(irq_t0_off), .irq_t1(irq_t1_off), .wdt_rst(wdt_rst_off));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic off_seen = 1'b0;
    always @(negedge clk) if (!rst && wdt_rst_off) off_seen <= 1'b1;

    int n_chk = 0, n_bad = 0, last_e = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        last_e = cyc;
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    // value, slow select, expected clocks from write to flag
    localparam int T0_VEC [6][3] = '{
        '{3, 0, 12}, '{1, 0, 4}, '{5, 0, 20}, '{2, 1, 32}, '{1, 1, 16}, '{255, 0, 1020}
    };

    initial begin
        logic [7:0] v;
        int e;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R1 register", v, 0);
        end
        check("R1 irq", {irq_div, irq_t0, irq_t1, wdt_rst}, 0);

        // R2 / R3 timer 0 periods
        for (int i = 0; i < 6; i++) begin
            wr(ADR_CTRL, 8'(T0_VEC[i][1]));
            wr(ADR_FLAG, 8'h02);
            wr(ADR_T0, 8'(T0_VEC[i][0]));
            e = last_e;
            wait_to(e + T0_VEC[i][2] - 1);
            check(T0_VEC[i][1] ? "R3 early" : "R2 early", irq_t0, 0);
            wait_to(e + T0_VEC[i][2]);
            check(T0_VEC[i][1] ? "R3 flag" : "R2 flag", irq_t0, 1);
            rd(ADR_T0, v);
            check("R2 count zero", v, 0);
            wait_to(e + T0_VEC[i][2] + 40);
            rd(ADR_T0, v);
            check("R4 stays stopped", v, 0);
        end

        // R4 writing zero
        wr(ADR_CTRL, 8'h00);
        wr(ADR_FLAG, 8'h02);
        wr(ADR_T0, 8'h00);
        e = last_e;
        wait_to(e + 40);
        check("R4 zero write no flag", irq_t0, 0);

        // R10 set beats clear, write 0 keeps
        wr(ADR_T0, 8'h01);
        e = last_e;
        wait_to(e + 3);
        wr(ADR_FLAG, 8'h02);
        check("R10 set wins", irq_t0, 1);
        wr(ADR_FLAG, 8'h00);
        check("R10 write 0 keeps", irq_t0, 1);
        wr(ADR_FLAG, 8'h02);
        check("R10 write 1 clears", irq_t0, 0);

        // R5 timer 1 internal
        wr(ADR_CTRL, 8'h04);
        wr(ADR_T1, 8'd3);
        e = last_e;
        wr(ADR_FLAG, 8'h04);
        wait_to(e + 4);
        rd(ADR_T1, v);
        check("R5 first step", v, 2);
        wait_to(e + 11);
        check("R5 early", irq_t1, 0);
        wait_to(e + 12);
        check("R5 flag", irq_t1, 1);
        rd(ADR_T1, v);
        check("R5 reloaded", v, 3);
        wr(ADR_FLAG, 8'h04);
        wait_to(e + 23);
        check("R5 second early", irq_t1, 0);
        wait_to(e + 24);
        check("R5 second flag", irq_t1, 1);

        // R7 stopped
        wr(ADR_CTRL, 8'h00);
        wr(ADR_T1, 8'd4);
        wr(ADR_FLAG, 8'h04);
        e = last_e;
        wait_to(e + 30);
        rd(ADR_T1, v);
        check("R7 hold count", v, 4);
        check("R7 no flag", irq_t1, 0);

        // R6 external events
        wr(ADR_CTRL, 8'h06);
        wr(ADR_T1, 8'd5);
        wr(ADR_FLAG, 8'h04);
        e = cyc;
        ev_pin = 1'b1;
        wait_to(e + 2);
        rd(ADR_T1, v);
        check("R6 before sync", v, 5);
        wait_to(e + 3);
        rd(ADR_T1, v);
        check("R6 third edge", v, 4);
        wait_to(e + 10);
        ev_pin = 1'b0;
        wait_to(e + 16);
        rd(ADR_T1, v);
        check("R6 level and fall ignored", v, 4);
        for (int k = 0; k < 4; k++) begin
            ev_pin = 1'b1;
            repeat (2) @(negedge clk);
            ev_pin = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        rd(ADR_T1, v);
        check("R6 reload after events", v, 5);
        check("R6 flag", irq_t1, 1);

        // R8 divider
        wr(ADR_CMD, 8'h01);
        e = last_e;
        wr(ADR_FLAG, 8'h01);
        wait_to(e + 63);
        check("R8 early", irq_div, 0);
        wait_to(e + 64);
        check("R8 wrap flag", irq_div, 1);

        // R9 clear on the wrapping cycle
        wr(ADR_CMD, 8'h01);
        e = last_e;
        wr(ADR_FLAG, 8'h01);
        wait_to(e + 63);
        wr(ADR_CMD, 8'h01);
        check("R9 clear wins", irq_div, 0);
        e = last_e;
        wait_to(e + 63);
        check("R9 next early", irq_div, 0);
        wait_to(e + 64);
        check("R9 next flag", irq_div, 1);

        // R11 watchdog short then long
        wr(ADR_CTRL, 8'h08);
        wr(ADR_CMD, 8'h02);
        e = last_e;
        wait_to(e + 31);
        check("R11 short early", wdt_rst, 0);
        wait_to(e + 32);
        check("R11 short pulse", wdt_rst, 1);
        wait_to(e + 33);
        check("R11 one cycle", wdt_rst, 0);
        wait_to(e + 64);
        check("R11 restart", wdt_rst, 1);
        wr(ADR_CTRL, 8'h00);
        wr(ADR_CMD, 8'h02);
        e = last_e;
        wait_to(e + 255);
        check("R11 long early", wdt_rst, 0);
        wait_to(e + 256);
        check("R11 long pulse", wdt_rst, 1);

        // R12 disabled watchdog
        check("R12 no pulse", off_seen, 0);

        summary();
    end
endmodule